// File: doc/BRIEF.md
# Programmable-Priority Vectored Interrupt Controller

This block gathers up to 32 level-sensitive request lines and reduces them to one interrupt line for a processor. Software controls each source through three settings: an enable bit, a 4-bit urgency value and a handler address. The handler addresses are held in a small memory. Smaller urgency values win. When several enabled sources with a high request share the best value, the source with the lowest index wins. A high index with a small value still beats a low index with a larger value.

The processor reads an acknowledge register to claim the current winner. That read returns the winner's handler address and marks the winner as in service. While a source is in service, the interrupt line rises again only for a source that is strictly more urgent. A write to the end-of-service register releases the claim. When no source qualifies, the acknowledge read returns a programmable fallback address and claims nothing.

Register map. The bus address is split into a 3-bit region field at `bus_addr[IDX_W+2:IDX_W]` and an index field at `bus_addr[IDX_W-1:0]`:

- Region 0: handler address of source `index`.
- Region 1: urgency of source `index`, held in bits [3:0].
- Region 2: control registers, selected by `bus_addr[1:0]`:
  - 0: enable mask, bit i enables source i.
  - 1: fallback address.
  - 2: acknowledge, read only.
  - 3: end of service, written with any data.

Read data appears on `bus_rdata` one clock after the read strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every urgency register reads 15, the enable mask reads 0, the fallback address reads 0 and `irq_out` is low.
- R2: Each source has its own 4-bit urgency, read back from region 1. Among competing sources the smallest value wins, whatever the indices are.
- R3: A source competes only when its enable bit is 1 and its request line is high. A high request on a disabled source leaves `irq_out` low.
- R4: When competing sources share the best urgency value, the lowest index wins.
- R5: `irq_out` is registered. It rises on the first clock edge at which a qualifying source is present.
- R6: An acknowledge read returns the winner's handler address one clock later and marks that source as in service. `irq_out` is low in the following cycle unless a strictly more urgent source is present.
- R7: While a source is in service, `irq_out` stays low for pending sources of equal or lower urgency. It rises for a source with a strictly smaller urgency value.
- R8: A write to end of service clears the in-service state. Any still-pending enabled source then raises `irq_out` again.
- R9: With no qualifying source, `irq_out` is low and an acknowledge read returns the fallback address.
- R10: Handler addresses written in region 0 read back unchanged at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_SRC | Level request lines, bit i is source i |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address (region and index) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one clock after `bus_rd` |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The arbitration is tried with several request patterns, and each pattern separates a different rule:

- All lines high with the whole enable mask clear, which separates gating from arbitration.
- Two sources at the reset urgency, which exposes the tie rule.
- A high-index source with a small urgency value against lower-index sources, which shows that index order does not decide.
- Nested arrivals of equal and then strictly better urgency during service, which separates the strict-comparison rule from a less-or-equal one.
- An acknowledge with nothing pending, which shows the fallback address is used and that no claim is latched.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    RG_VEC = 3'd0,
    RG_PRI = 3'd1,
    RG_CTL = 3'd2
  } pic_region_e;

  typedef enum logic [1:0] {
    CT_ENABLE  = 2'd0,
    CT_DEFAULT = 2'd1,
    CT_ACK     = 2'd2,
    CT_EOS     = 2'd3
  } pic_ctl_e;
endpackage

// File: rtl/pic_vec_ram.sv
module pic_vec_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SRC-1:0]             elig,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           win_valid,
  output logic [IDX_W-1:0]               win_idx,
  output logic [PRIO_W-1:0]              win_prio
);
  // Linear scan: strict less-than keeps the lowest index on ties.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!win_valid || prio[i] < win_prio)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = prio[i];
      end
    end
  end

  // Cross-check the chosen winner against every competitor.
  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        p_winner_best_r2: assert (!(elig[i] && win_valid && prio[i] < win_prio))
          else $error("competitor %0d more urgent than winner", i);
        p_tie_low_index_r4: assert (!(elig[i] && win_valid && prio[i] == win_prio && IDX_W'(i) < win_idx))
          else $error("tie resolved away from lower index %0d", i);
      end
      p_winner_eligible_r3: assert (!win_valid || elig[win_idx])
        else $error("winner not eligible");
    end
  end
endmodule

// File: rtl/pic_service.sv
module pic_service #(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic              ack,
  input  logic              eos,
  output logic              cand,
  output logic              irq_q
);
  logic              svc_active;
  logic [PRIO_W-1:0] svc_prio;

  // A winner is offered only if idle, or strictly more urgent than the claim.
  assign cand = win_valid && (!svc_active || win_prio < svc_prio);

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_active <= 1'b0;
      svc_prio   <= '1;
      irq_q      <= 1'b0;
    end else begin
      if (eos) svc_active <= 1'b0;
      if (ack && cand) begin
        svc_active <= 1'b1;
        svc_prio   <= win_prio;
      end
      irq_q <= cand && !ack;
    end
  end

  p_ack_claims_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && cand) |=> svc_active);
  p_eos_releases_r8: assert property (@(posedge clk) disable iff (rst)
    (eos && !ack) |=> !svc_active);
  p_claim_tracks_winner_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && cand) |=> (svc_prio == $past(win_prio)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);
  import pic_pkg::*;

  localparam int IDX_W = $clog2(NUM_SRC);

  pic_region_e region;
  pic_ctl_e    ctl_off;
  logic [IDX_W-1:0] idx;

  assign region  = pic_region_e'(bus_addr[IDX_W +: 3]);
  assign ctl_off = pic_ctl_e'(bus_addr[1:0]);
  assign idx     = bus_addr[IDX_W-1:0];

  logic wr_vec, wr_pri, wr_en, wr_def, ack, eos;
  assign wr_vec = bus_wr && region == RG_VEC;
  assign wr_pri = bus_wr && region == RG_PRI;
  assign wr_en  = bus_wr && region == RG_CTL && ctl_off == CT_ENABLE;
  assign wr_def = bus_wr && region == RG_CTL && ctl_off == CT_DEFAULT;
  assign eos    = bus_wr && region == RG_CTL && ctl_off == CT_EOS;
  assign ack    = bus_rd && region == RG_CTL && ctl_off == CT_ACK;

  // Configuration held in flops: urgency and enables feed the arbiter in parallel.
  logic [NUM_SRC-1:0]             en_mask;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [VEC_W-1:0]               def_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_mask <= '0;
      def_vec <= '0;
      for (int i = 0; i < NUM_SRC; i++) prio[i] <= '1;
    end else begin
      if (wr_en)  en_mask   <= bus_wdata[NUM_SRC-1:0];
      if (wr_def) def_vec   <= bus_wdata[VEC_W-1:0];
      if (wr_pri) prio[idx] <= bus_wdata[PRIO_W-1:0];
    end
  end

  logic                elig;
  logic [NUM_SRC-1:0]  elig_v;
  logic                win_valid;
  logic [IDX_W-1:0]    win_idx;
  logic [PRIO_W-1:0]   win_prio;
  logic                cand;

  assign elig_v = irq_src & en_mask;
  assign elig   = |elig_v;

  pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk(clk), .rst(rst), .elig(elig_v), .prio(prio),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  pic_service #(.PRIO_W(PRIO_W)) u_svc (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_prio(win_prio),
    .ack(ack), .eos(eos), .cand(cand), .irq_q(irq_out)
  );

  // Handler addresses: one synchronous read port shared by bus reads and acknowledge.
  logic [VEC_W-1:0] vec_q;
  logic [IDX_W-1:0] vec_raddr;
  assign vec_raddr = ack ? win_idx : idx;

  pic_vec_ram #(.DEPTH(NUM_SRC), .WIDTH(VEC_W)) u_vec (
    .clk(clk), .we(wr_vec), .waddr(idx), .wdata(bus_wdata[VEC_W-1:0]),
    .raddr(vec_raddr), .rdata(vec_q)
  );

  logic              use_mem;
  logic [DATA_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      use_mem <= 1'b0;
      reg_q   <= '0;
    end else if (bus_rd) begin
      use_mem <= 1'b0;
      reg_q   <= '0;
      case (region)
        RG_VEC: use_mem <= 1'b1;
        RG_PRI: reg_q   <= DATA_W'(prio[idx]);
        RG_CTL: begin
          case (ctl_off)
            CT_ENABLE:  reg_q <= DATA_W'(en_mask);
            CT_DEFAULT: reg_q <= DATA_W'(def_vec);
            CT_ACK: begin
              use_mem <= cand;
              reg_q   <= DATA_W'(def_vec);
            end
            default:    reg_q <= '0;
          endcase
        end
        default: reg_q <= '0;
      endcase
    end
  end

  assign bus_rdata = use_mem ? DATA_W'(vec_q) : reg_q;

  p_irq_needs_source_r3: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(elig));
  p_idle_no_irq_r9: assert property (@(posedge clk) disable iff (rst)
    !elig |=> !irq_out);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] irq_src = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] a_vec(int i); return {3'd0, 5'(i)}; endfunction
  function automatic logic [7:0] a_pri(int i); return {3'd1, 5'(i)}; endfunction
  localparam logic [7:0] A_EN  = {3'd2, 5'd0};
  localparam logic [7:0] A_DEF = {3'd2, 5'd1};
  localparam logic [7:0] A_ACK = {3'd2, 5'd2};
  localparam logic [7:0] A_EOS = {3'd2, 5'd3};

  function automatic logic [31:0] vec_of(int i); return 32'h0800_0000 + 32'(i * 4); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq_out), 32'd0);
    rd(a_pri(0), d);  chk("R1 prio0", d, 32'd15);
    rd(a_pri(31), d); chk("R1 prio31", d, 32'd15);
    rd(A_EN, d);      chk("R1 enable", d, 32'd0);
    rd(A_DEF, d);     chk("R1 fallback", d, 32'd0);
  endtask

  task automatic t_vectors();
    logic [31:0] d;
    for (int i = 0; i < N; i++) wr(a_vec(i), vec_of(i));
    rd(a_vec(0), d);  chk("R10 vec0", d, vec_of(0));
    rd(a_vec(17), d); chk("R10 vec17", d, vec_of(17));
    rd(a_vec(31), d); chk("R10 vec31", d, vec_of(31));
    wr(a_pri(6), 32'd9);
    rd(a_pri(6), d);  chk("R2 prio readback", d, 32'd9);
    wr(a_pri(6), 32'd15);
  endtask

  task automatic t_gating();
    @(negedge clk); irq_src = '1;
    settle(); settle();
    chk("R3 all disabled", 32'(irq_out), 32'd0);
    @(negedge clk); irq_src = '0;
    wr(A_EN, 32'h0000_0020);
    settle();
    chk("R3 enabled no request", 32'(irq_out), 32'd0);
    @(negedge clk); irq_src[5] = 1'b1;
    chk("R5 before edge", 32'(irq_out), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R5 one edge later", 32'(irq_out), 32'd1);
    @(negedge clk); irq_src[5] = 1'b0;
    settle();
    chk("R9 idle irq low", 32'(irq_out), 32'd0);
  endtask

  task automatic t_tie();
    logic [31:0] d;
    wr(A_EN, (32'd1 << 3) | (32'd1 << 9));
    @(negedge clk); irq_src[3] = 1'b1; irq_src[9] = 1'b1;
    settle();
    chk("R5 tie irq", 32'(irq_out), 32'd1);
    rd(A_ACK, d); chk("R4 tie lowest index", d, vec_of(3));
    chk("R6 irq low after ack", 32'(irq_out), 32'd0);
    settle();
    chk("R7 same level blocked", 32'(irq_out), 32'd0);
    wr(A_EOS, 32'd0);
    settle();
    chk("R8 irq after release", 32'(irq_out), 32'd1);
    rd(A_ACK, d); chk("R6 ack again", d, vec_of(3));
    wr(A_EOS, 32'd0);
  endtask

  task automatic t_prio_nest();
    logic [31:0] d;
    wr(a_pri(20), 32'd2);
    wr(a_pri(3), 32'd7);
    wr(A_EN, (32'd1 << 3) | (32'd1 << 9) | (32'd1 << 20));
    @(negedge clk); irq_src[20] = 1'b1;
    settle();
    rd(A_ACK, d); chk("R2 small value beats low index", d, vec_of(20));
    wr(a_pri(9), 32'd2);
    settle();
    chk("R7 equal urgency blocked", 32'(irq_out), 32'd0);
    wr(a_pri(25), 32'd1);
    wr(A_EN, (32'd1 << 3) | (32'd1 << 9) | (32'd1 << 20) | (32'd1 << 25));
    @(negedge clk); irq_src[25] = 1'b1;
    settle();
    chk("R7 strictly better raises", 32'(irq_out), 32'd1);
    rd(A_ACK, d); chk("R6 preempting vector", d, vec_of(25));
    chk("R6 irq low after ack", 32'(irq_out), 32'd0);
    @(negedge clk); irq_src[25] = 1'b0;
    wr(A_EOS, 32'd0);
    settle();
    chk("R8 pending raises after release", 32'(irq_out), 32'd1);
    rd(A_ACK, d); chk("R4 tie at level 2", d, vec_of(9));
    wr(A_EOS, 32'd0);
    @(negedge clk); irq_src = '0;
    settle();
  endtask

  task automatic t_fallback();
    logic [31:0] d;
    wr(A_DEF, 32'h0000_BEEF);
    settle();
    chk("R9 irq low idle", 32'(irq_out), 32'd0);
    rd(A_ACK, d); chk("R9 fallback vector", d, 32'h0000_BEEF);
    @(negedge clk); irq_src[3] = 1'b1;
    settle();
    chk("R9 no claim latched", 32'(irq_out), 32'd1);
    rd(A_ACK, d); chk("R6 vector after fallback", d, vec_of(3));
    wr(A_EOS, 32'd0);
    @(negedge clk); irq_src = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_vectors();
    t_gating();
    t_tie();
    t_prio_nest();
    t_fallback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule